// File: doc/BRIEF.md
# Serial display PHY bring-up sequencer

This block owns the four control bits of a serial display PHY and steps the PHY from a held, powered-down state to an operating state. A start-of-day init request keeps the PHY in shutdown and reset with all control bits low, and drives the PHY test-clear line low, then high for a programmable number of cycles, then low again.

An enable request sets all four control bits in the same cycle. The block then waits for the PLL lock indication, and after that for the clock-lane stop-state indication. Each wait is bounded by its own cycle-count limit. A wait that runs out sets its own sticky flag, and the sequence goes on to the next stage instead of stopping. When the second stage ends, a one-cycle done pulse is raised and busy drops. A disable request drops every control bit at once from any state. The analog PHY appears only as the two status inputs.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, phy_ctrl_o is 4'b0000 and test_clr_o, busy_o, done_o, lock_to_o and stop_to_o are all low.
- R2: An init_i pulse that is sampled while the sequencer is idle drives test_clr_o low for one cycle, then high for CLR_HI_CYC cycles, then low. phy_ctrl_o stays 4'b0000 throughout. test_clr_o is high only while phy_ctrl_o is zero.
- R3: An enable_i that is sampled while idle, with no test-clear pulse in progress and init_i low, sets phy_ctrl_o to 4'b1111 on the next cycle and raises busy_o. The bits are: bit 0 releases shutdown, bit 1 releases reset, bit 2 enables the clock, bit 3 forces the PLL. phy_ctrl_o is only ever 4'b0000 or 4'b1111, and busy_o implies 4'b1111.
- R4: The first stage ends on the first clock edge at which pll_lock_i is sampled high. clk_stop_i is only considered in the second stage, which ends on the first edge at which clk_stop_i is sampled high.
- R5: If pll_lock_i is not seen within LOCK_TO_CYC edges after enable, lock_to_o is set at edge LOCK_TO_CYC and the second stage begins. A lock that is seen on that exact edge is not a timeout.
- R6: If clk_stop_i is not seen within STOP_TO_CYC edges of the second stage, stop_to_o is set and the sequence completes.
- R7: When the second stage ends, done_o is high for exactly one cycle, busy_o falls in the same cycle, and phy_ctrl_o stays 4'b1111. A run with both status inputs already high completes two edges after enable is accepted.
- R8: disable_i clears phy_ctrl_o and busy_o on the next cycle from any state. An aborted run gives no done_o.
- R9: lock_to_o and stop_to_o stay set through disable. They are cleared only when a new enable is accepted.
- R10: enable_i has no effect while a run is in progress, after completion (before a disable), or while a test-clear pulse is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Request the test-clear pulse while held |
| enable_i | input | 1 | Request bring-up |
| disable_i | input | 1 | Return the PHY to the held state |
| pll_lock_i | input | 1 | PHY PLL locked |
| clk_stop_i | input | 1 | PHY clock lane in stop state |
| phy_ctrl_o | output | 4 | PHY control word (unshutdown, unreset, clock enable, force PLL) |
| test_clr_o | output | 1 | PHY test-clear line |
| busy_o | output | 1 | Bring-up in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lock_to_o | output | 1 | Sticky: lock wait timed out |
| stop_to_o | output | 1 | Sticky: stop-state wait timed out |

## Verification
The bench builds the block with LOCK_TO_CYC=20, STOP_TO_CYC=12 and CLR_HI_CYC=3 in place of the 10 ms default limits. With these values both timeouts, and the case where they both occur, complete within a few dozen cycles. The exact edge at which lock arrives together with the limit, and the edge just after it, can then be compared cycle for cycle against a completion latency computed in the bench. The short high phase lets the bench check every cycle of the test-clear pulse, including an enable sent into the middle of it.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned CTRL_UNSHUT = 0;
  localparam int unsigned CTRL_UNRST  = 1;
  localparam int unsigned CTRL_CLKEN  = 2;
  localparam int unsigned CTRL_PLLFRC = 3;
  localparam int unsigned N_STAGE = 2;

  typedef logic [CTRL_W-1:0] phy_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_LOCK,
    ST_WAIT_STOP,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/phy_seq_wait.sv
module phy_seq_wait #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic cond_i,
  output logic hit_o,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!active_i)                 cnt_q <= '0;
    else if (!cond_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  // condition wins over expiry on the same edge
  assign hit_o    = active_i & cond_i;
  assign expire_o = active_i & ~cond_i & (cnt_q == LAST);

  AST_WAIT_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
  AST_WAIT_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0); // R6
endmodule

// File: rtl/phy_seq_clr.sv
module phy_seq_clr #(
  parameter int unsigned HI_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic clr_o
);
  localparam int unsigned CW = (HI_CYC > 1) ? $clog2(HI_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HI_CYC - 1);

  typedef enum logic [1:0] {P_IDLE, P_LO, P_HI} phase_e;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= P_IDLE;
      cnt_q <= '0;
      clr_q <= 1'b0;
    end else begin
      unique case (ph_q)
        P_IDLE: if (start_i) begin
          ph_q  <= P_LO;
          clr_q <= 1'b0;
        end
        P_LO: begin
          ph_q  <= P_HI;
          clr_q <= 1'b1;
          cnt_q <= '0;
        end
        P_HI: begin
          if (cnt_q == LAST) begin
            ph_q  <= P_IDLE;
            clr_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  assign busy_o = (ph_q != P_IDLE);
  assign clr_o  = clr_q;

  AST_CLR_INSIDE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> busy_o); // R2
  AST_CLR_LEADS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_o) |-> $past(busy_o)); // R2
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned LOCK_TO_CYC = 2000000,
  parameter int unsigned STOP_TO_CYC = 2000000,
  parameter int unsigned CLR_HI_CYC  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        enable_i,
  input  logic        disable_i,
  input  logic        pll_lock_i,
  input  logic        clk_stop_i,
  output logic [3:0]  phy_ctrl_o,
  output logic        test_clr_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        lock_to_o,
  output logic        stop_to_o
);
  localparam phy_ctrl_t CTRL_UP = phy_ctrl_t'((1 << CTRL_UNSHUT) | (1 << CTRL_UNRST)
                                             | (1 << CTRL_CLKEN) | (1 << CTRL_PLLFRC));

  seq_state_e         st_q;
  phy_ctrl_t          ctrl_q;
  logic               busy_q, done_q, lock_to_q, stop_to_q;
  logic               clr_busy, clr_line, clr_start, en_ok;
  logic [N_STAGE-1:0] stg_act, stg_cond, stg_hit, stg_exp;

  assign clr_start = init_i & ~disable_i & (st_q == ST_IDLE) & ~clr_busy;
  assign en_ok     = enable_i & ~init_i & ~disable_i & (st_q == ST_IDLE) & ~clr_busy;

  phy_seq_clr #(.HI_CYC(CLR_HI_CYC)) u_clr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (clr_start),
    .busy_o  (clr_busy),
    .clr_o   (clr_line)
  );

  assign stg_act  = {st_q == ST_WAIT_STOP, st_q == ST_WAIT_LOCK};
  assign stg_cond = {clk_stop_i, pll_lock_i};

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    localparam int unsigned LIM = (g == 0) ? LOCK_TO_CYC : STOP_TO_CYC;
    phy_seq_wait #(.LIMIT(LIM)) u_wait (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (stg_act[g]),
      .cond_i   (stg_cond[g]),
      .hit_o    (stg_hit[g]),
      .expire_o (stg_exp[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ctrl_q    <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      lock_to_q <= 1'b0;
      stop_to_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (disable_i) begin
        st_q   <= ST_IDLE;
        ctrl_q <= '0;
        busy_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (en_ok) begin
            st_q      <= ST_WAIT_LOCK;
            ctrl_q    <= CTRL_UP;
            busy_q    <= 1'b1;
            lock_to_q <= 1'b0;
            stop_to_q <= 1'b0;
          end
          ST_WAIT_LOCK: if (stg_hit[0] | stg_exp[0]) begin
            st_q <= ST_WAIT_STOP;
            if (stg_exp[0]) lock_to_q <= 1'b1;
          end
          ST_WAIT_STOP: if (stg_hit[1] | stg_exp[1]) begin
            st_q   <= ST_RUN;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (stg_exp[1]) stop_to_q <= 1'b1;
          end
          ST_RUN: ;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign phy_ctrl_o = ctrl_q;
  assign test_clr_o = clr_line;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign lock_to_o  = lock_to_q;
  assign stop_to_o  = stop_to_q;

  AST_CTRL_WHOLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_ctrl_o == 4'h0 || phy_ctrl_o == 4'hF); // R3
  AST_BUSY_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> phy_ctrl_o == 4'hF); // R3
  AST_CLR_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_clr_o |-> phy_ctrl_o == 4'h0); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o); // R7
  AST_DISABLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> phy_ctrl_o == 4'h0 && !busy_o && !done_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lock_to_o) || $fell(stop_to_o)) |-> busy_o); // R9
endmodule

// File: tb/sim_phy_bringup_seq.sv
`timescale 1ns/1ps
module sim_phy_bringup_seq;
  localparam int LK = 20;
  localparam int ST = 12;
  localparam int HI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, en = 1'b0, dis = 1'b0, lock = 1'b0, stop = 1'b0;
  logic [3:0] ctrl;
  logic clr, busy, done, lto, sto;

  int errors = 0, checks = 0, cyc = 0, ecyc = 0;

  typedef struct { int lat; bit lto; bit sto; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_bringup_seq #(.LOCK_TO_CYC(LK), .STOP_TO_CYC(ST), .CLR_HI_CYC(HI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .enable_i(en), .disable_i(dis),
    .pll_lock_i(lock), .clk_stop_i(stop), .phy_ctrl_o(ctrl), .test_clr_o(clr),
    .busy_o(busy), .done_o(done), .lock_to_o(lto), .stop_to_o(sto));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected completions as done pulses appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8 or R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc - ecyc == e.lat, "R4 R7 completion latency", cyc - ecyc, e.lat);
        chk(lto == e.lto, "R5 lock timeout flag", lto, e.lto);
        chk(sto == e.sto, "R6 stop timeout flag", sto, e.sto);
      end
    end
  end

  // a: first edge after enable with lock high; sb: same for stop; rep: re-enable index
  task automatic run(input int a, input int sb, input int rep);
    exp_t e;
    int xo, ts;
    xo = (a <= LK) ? a : LK;
    e.lto = (a > LK);
    ts = (sb > xo + 1) ? sb : xo + 1;
    e.sto = (ts > xo + ST);
    e.lat = e.sto ? xo + ST : ts;
    q.push_back(e);
    @(negedge clk);
    en = 1'b1; lock = 1'b0; stop = 1'b0;
    ecyc = cyc + 1;
    for (int i = 1; i <= e.lat + 2; i++) begin
      @(negedge clk);
      en = (i == rep);
      lock = (i >= a);
      stop = (i >= sb);
      if (i == 1) begin
        chk(ctrl == 4'hF, "R3 control word up", ctrl, 15);
        chk(busy == 1'b1, "R3 busy after enable", busy, 1);
        chk(!lto && !sto, "R9 flags cleared by enable", {lto, sto}, 0);
      end
    end
    en = 1'b0;
    chk(q.size() == 0, "R7 done seen", q.size(), 0);
    chk(!busy && ctrl == 4'hF, "R7 up and idle after done", {busy, ctrl}, 15);
  endtask

  task automatic shut();
    @(negedge clk);
    dis = 1'b1; lock = 1'b0; stop = 1'b0;
    @(negedge clk);
    dis = 1'b0;
    chk(ctrl == 4'h0 && !busy, "R8 disable clears", {busy, ctrl}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl == 4'h0 && !clr && !busy && !done && !lto && !sto, "R1 reset state",
        {ctrl, clr, busy, done, lto, sto}, 0);

    // R2 test-clear pulse, enable during it ignored (R10)
    @(negedge clk);
    init = 1'b1;
    for (int j = 0; j <= HI + 2; j++) begin
      @(negedge clk);
      init = 1'b0;
      en = (j == 1);
      chk(clr == (j >= 1 && j <= HI), "R2 test-clear shape", clr, (j >= 1 && j <= HI));
      chk(ctrl == 4'h0, "R2 R10 held during clear", ctrl, 0);
    end
    en = 1'b0;

    run(1, 1, 0);      // immediate
    shut();
    run(5, 9, 3);      // mid-wait arrivals, re-enable while busy (R10)
    // R10 enable after completion ignored
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
    repeat (4) @(negedge clk);
    chk(ctrl == 4'hF && !busy, "R10 enable after done ignored", {busy, ctrl}, 15);
    shut();
    run(100, 1, 0);    // R5 lock timeout
    shut();
    run(3, 100, 0);    // R6 stop timeout
    shut();
    run(LK, 1, 0);     // R5 lock on the limit edge: no timeout
    shut();
    run(LK + 1, 1, 0); // R5 one edge late
    shut();
    run(100, 100, 0);  // both time out
    shut();
    chk(lto && sto, "R9 flags sticky through disable", {lto, sto}, 3);

    // R8 abort mid-wait
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R4 waiting without lock", busy, 1);
    dis = 1'b1;
    @(negedge clk); dis = 1'b0;
    chk(ctrl == 4'h0 && !busy, "R8 abort clears", {busy, ctrl}, 0);
    chk(!lto && !sto, "R9 new enable cleared flags", {lto, sto}, 0);
    lock = 1'b1; stop = 1'b1;
    repeat (LK + ST + 4) @(negedge clk);
    chk(ctrl == 4'h0 && !busy, "R8 stays held after abort", {busy, ctrl}, 0);
    lock = 1'b0; stop = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule